// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block sits between an internal single-word request bus and an external asynchronous static RAM with a 16-bit data path split into two byte lanes. Each accepted request turns into a fixed sequence of active-low strobes: chip select, write strobe, output strobe and one select per byte lane. Every window is a whole number of system clock cycles. The cycle counts are parameters, and elaboration-time checks compare them against the RAM's nanosecond minimums at the configured clock period.

Requests use a valid/ready handshake. Each request carries an address, a write flag, a per-lane mask and write data. A read returns its data with a one-cycle valid pulse. The data pins appear as separate out, in and drive-enable signals, so the bidirectional pad sits outside the block. When a write follows a read, the block inserts idle turnaround cycles so that the RAM has released the bus before the controller starts to drive it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and on release, chip select, write strobe, output strobe and both lane selects are high, the data driver is off, ready is high and read-valid is low.
- R2: A write holds chip select and write strobe low together for exactly WR_CYC cycles with the output strobe high. The lane selects equal the inverted mask, where mask bit 0 selects dq[7:0] and bit 1 selects dq[15:8]. The address stays stable for the whole window.
- R3: The data driver is on with stable data from the first write-strobe cycle through the one cycle after the write strobe rises. It is off at all other times, and never on while the output strobe is low.
- R4: A read holds chip select and output strobe low for exactly RD_CYC cycles with the write strobe high and the driver off. The lane selects equal the inverted mask and the address is stable.
- R5: Read data is sampled on the clock edge that closes the read window. Read-valid is a one-cycle pulse in the same cycle the output strobe rises. Lanes whose mask bit is 0 return zero.
- R6: A write accepted right after a read keeps all strobes high and the driver off for TA_CYC cycles. As a result, the driver turns on exactly TA_CYC+1 cycles after the output strobe rises. A write that does not follow a read starts its strobes in the cycle after acceptance.
- R7: Ready is high only while idle. With request-valid low, no strobe moves.
- R8: A write with mask 0 asserts no lane select and leaves the RAM contents unchanged. A one-lane write changes only that lane.
- R9: A write keeps ready low for WR_CYC+1 cycles after acceptance (TA_CYC more after a read). A read keeps ready low for RD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_mask_i | input | DATA_W/8 | Byte lane mask, bit n = lane n |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | DATA_W | Captured read data |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_ce_n_o | output | 1 | RAM chip select, active low |
| ram_we_n_o | output | 1 | RAM write strobe, active low |
| ram_oe_n_o | output | 1 | RAM output strobe, active low |
| ram_be_n_o | output | DATA_W/8 | RAM lane selects, active low |
| ram_dq_o | output | DATA_W | Data to pad |
| ram_dq_oe_o | output | 1 | Pad driver enable |
| ram_dq_i | input | DATA_W | Data from pad |

## Verification
Errors in the sequencer state or the window counter show up at the pins within a cycle as a strobe window of the wrong length. The strobe-length monitors catch such a window on the edge where the strobe rises. A stale "last operation was a read" flag either drops the turnaround, which shows as the driver turning on while the RAM may still drive, or adds turnaround to writes, which shows as late write strobes. A wrong mask latch or a swapped lane only shows up when the data is read back. For that reason, partial and empty masks are each written and then read.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WRITE,
    ST_WREC,
    ST_READ
  } state_e;

  // RAM minimums in ps
  localparam int unsigned T_WPULSE_PS = 8000;
  localparam int unsigned T_WCYCLE_PS = 10000;
  localparam int unsigned T_DSETUP_PS = 6000;
  localparam int unsigned T_ASETUP_PS = 7000;
  localparam int unsigned T_RCYCLE_PS = 10000;
  localparam int unsigned T_ADATA_PS  = 10000;
  localparam int unsigned T_OEDATA_PS = 4000;
  localparam int unsigned T_BEDATA_PS = 5000;
  localparam int unsigned T_RELEASE_PS = 5000;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_cnt.sv
`timescale 1ns/1ps
module sram_ctrl_cnt #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_rcap.sv
`timescale 1ns/1ps
module sram_ctrl_rcap #(
  parameter int unsigned LANES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [LANES-1:0]   lane_en_i,
  input  logic [LANES*8-1:0] dq_i,
  output logic [LANES*8-1:0] rdata_o,
  output logic               rvalid_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q <= 8'h00;
      else if (cap_i) lane_q <= lane_en_i[l] ? dq_i[l*8 +: 8] : 8'h00;
    end
    assign rdata_o[l*8 +: 8] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= cap_i;
  end

endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW     = 18,
  parameter int unsigned DW     = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned CW     = 2,
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned TA_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [LANES-1:0] req_mask_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             req_ready_o,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CW-1:0]    cnt_val_o,
  output logic             cap_o,
  output logic [LANES-1:0] lane_en_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic             ram_ce_n_o,
  output logic             ram_we_n_o,
  output logic             ram_oe_n_o,
  output logic [LANES-1:0] ram_be_n_o,
  output logic [DW-1:0]    ram_dq_o,
  output logic             ram_dq_oe_o
);

  state_e           state_q, state_d;
  logic             accept;
  logic             last_rd_q;
  logic [LANES-1:0] mask_q, mask_d;
  logic             sel_d;

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cap_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept     = 1'b1;
          cnt_load_o = 1'b1;
          if (!req_write_i) begin
            state_d   = ST_READ;
            cnt_val_o = CW'(RD_CYC - 1);
          end else if (last_rd_q) begin
            // bus release after output strobe
            state_d   = ST_TURN;
            cnt_val_o = CW'(TA_CYC - 1);
          end else begin
            state_d   = ST_WRITE;
            cnt_val_o = CW'(WR_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (cnt_zero_i) begin
          state_d    = ST_WRITE;
          cnt_load_o = 1'b1;
          cnt_val_o  = CW'(WR_CYC - 1);
        end
      end
      ST_WRITE: if (cnt_zero_i) state_d = ST_WREC;
      ST_WREC:  state_d = ST_IDLE;
      ST_READ: begin
        if (cnt_zero_i) begin
          state_d = ST_IDLE;
          cap_o   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mask_d = accept ? req_mask_i : mask_q;
  assign sel_d  = (state_d == ST_WRITE) || (state_d == ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      last_rd_q   <= 1'b0;
      mask_q      <= '0;
      ram_addr_o  <= '0;
      ram_dq_o    <= '0;
      ram_ce_n_o  <= 1'b1;
      ram_we_n_o  <= 1'b1;
      ram_oe_n_o  <= 1'b1;
      ram_be_n_o  <= '1;
      ram_dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      if (accept) begin
        last_rd_q  <= !req_write_i;
        ram_addr_o <= req_addr_i;
        ram_dq_o   <= req_wdata_i;
      end
      ram_ce_n_o  <= !sel_d;
      ram_we_n_o  <= !(state_d == ST_WRITE);
      ram_oe_n_o  <= !(state_d == ST_READ);
      ram_be_n_o  <= sel_d ? ~mask_d : '1;
      ram_dq_oe_o <= (state_d == ST_WRITE) || (state_d == ST_WREC);
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign lane_en_o   = mask_q;

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CLK_PS = 4000,
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned TA_CYC = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W/8-1:0] req_mask_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [ADDR_W-1:0]   ram_addr_o,
  output logic                ram_ce_n_o,
  output logic                ram_we_n_o,
  output logic                ram_oe_n_o,
  output logic [DATA_W/8-1:0] ram_be_n_o,
  output logic [DATA_W-1:0]   ram_dq_o,
  output logic                ram_dq_oe_o,
  input  logic [DATA_W-1:0]   ram_dq_i
);

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned CNT_TOP = max3(WR_CYC, RD_CYC, TA_CYC);
  localparam int unsigned CW      = (CNT_TOP < 2) ? 1 : $clog2(CNT_TOP);

  // elaboration-time timing checks
  if (DATA_W % 8 != 0) begin : g_bad_dw
    $error("DATA_W must be a multiple of 8");
  end
  if (WR_CYC < 1 || RD_CYC < 1 || TA_CYC < 1) begin : g_bad_zero
    $error("cycle counts must be at least 1");
  end
  if (WR_CYC * CLK_PS < max3(T_WPULSE_PS, T_DSETUP_PS, T_ASETUP_PS)) begin : g_bad_wr
    $error("WR_CYC too short for write pulse, data or address setup");
  end
  if ((WR_CYC + 1) * CLK_PS < T_WCYCLE_PS) begin : g_bad_wc
    $error("write cycle too short");
  end
  if (RD_CYC * CLK_PS < max3(T_RCYCLE_PS, T_ADATA_PS, max3(T_OEDATA_PS, T_BEDATA_PS, 0))) begin : g_bad_rd
    $error("RD_CYC too short for read access");
  end
  if ((TA_CYC + 1) * CLK_PS < T_RELEASE_PS) begin : g_bad_ta
    $error("TA_CYC too short for bus release");
  end

  logic             cnt_load, cnt_zero, cap;
  logic [CW-1:0]    cnt_val;
  logic [LANES-1:0] lane_en;

  sram_ctrl_seq #(
    .AW(ADDR_W), .DW(DATA_W), .LANES(LANES), .CW(CW),
    .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_mask_i  (req_mask_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .cnt_zero_i  (cnt_zero),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .cap_o       (cap),
    .lane_en_o   (lane_en),
    .ram_addr_o  (ram_addr_o),
    .ram_ce_n_o  (ram_ce_n_o),
    .ram_we_n_o  (ram_we_n_o),
    .ram_oe_n_o  (ram_oe_n_o),
    .ram_be_n_o  (ram_be_n_o),
    .ram_dq_o    (ram_dq_o),
    .ram_dq_oe_o (ram_dq_oe_o)
  );

  sram_ctrl_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  sram_ctrl_rcap #(.LANES(LANES)) u_rcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .lane_en_i (lane_en),
    .dq_i      (ram_dq_i),
    .rdata_o   (rsp_rdata_o),
    .rvalid_o  (rsp_valid_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned TA_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic ram_ce_n_o,
  input logic ram_we_n_o,
  input logic ram_oe_n_o,
  input logic ram_dq_oe_o
);

  localparam int unsigned WW = $clog2(WR_CYC + 2);
  localparam int unsigned RW = $clog2(RD_CYC + 2);
  localparam int unsigned TW = $clog2(TA_CYC + 2);

  logic [WW-1:0] we_run;
  logic [RW-1:0] oe_run;
  logic [TW-1:0] since_oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run   <= '0;
      oe_run   <= '0;
      since_oe <= '1;
    end else begin
      we_run   <= !ram_we_n_o ? ((we_run == '1) ? we_run : we_run + 1'b1) : '0;
      oe_run   <= !ram_oe_n_o ? ((oe_run == '1) ? oe_run : oe_run + 1'b1) : '0;
      since_oe <= !ram_oe_n_o ? '0 : ((since_oe == '1) ? since_oe : since_oe + 1'b1);
    end
  end

  p_we_in_ce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> !ram_ce_n_o);

  p_we_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_n_o) |-> (we_run == WW'(WR_CYC)));

  p_no_contention_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_n_o |-> !ram_dq_oe_o);

  p_oe_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_oe_n_o) |-> (oe_run == RW'(RD_CYC)));

  p_oe_we_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_oe_n_o && !ram_we_n_o));

  p_rvalid_at_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_oe_n_o) |-> rsp_valid_o);

  p_rvalid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_oe_n_o && since_oe <= TW'(TA_CYC)) |-> !ram_dq_oe_o);

  p_ready_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_ce_n_o && ram_we_n_o && ram_oe_n_o && !ram_dq_oe_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .ram_ce_n_o  (ram_ce_n_o),
  .ram_we_n_o  (ram_we_n_o),
  .ram_oe_n_o  (ram_oe_n_o),
  .ram_dq_oe_o (ram_dq_oe_o)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  localparam int unsigned AW = 18, DW = 16, WR = 2, RD = 3, TA = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_mask = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [1:0]    ram_be_n;
  logic [DW-1:0] ram_dq_o, ram_dq_i;

  int checks = 0, fails = 0, contention = 0;
  bit last_rd = 1'b0, done = 1'b0;
  logic [15:0] mem [16];
  logic [15:0] shadow [16];

  always #2 clk = ~clk; // 4 ns period

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(4000),
              .WR_CYC(WR), .RD_CYC(RD), .TA_CYC(TA)) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_mask_i(req_mask), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ram_addr_o(ram_addr), .ram_ce_n_o(ram_ce_n), .ram_we_n_o(ram_we_n),
    .ram_oe_n_o(ram_oe_n), .ram_be_n_o(ram_be_n), .ram_dq_o(ram_dq_o),
    .ram_dq_oe_o(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  // RAM model: masked lanes return filler so the capture must zero them
  wire [3:0] ma = ram_addr[3:0];
  assign ram_dq_i = (!ram_ce_n && !ram_oe_n) ?
    {ram_be_n[1] ? 8'hA5 : mem[ma][15:8], ram_be_n[0] ? 8'h5A : mem[ma][7:0]} : 16'hDEAD;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ram_ce_n && !ram_we_n && ram_dq_oe) begin
        if (!ram_be_n[0]) mem[ma][7:0]  <= ram_dq_o[7:0];
        if (!ram_be_n[1]) mem[ma][15:8] <= ram_dq_o[15:8];
      end
      if (!ram_oe_n && ram_dq_oe) contention++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [1:0] m, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_mask = m; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [1:0] m, input logic [DW-1:0] d);
    bit after = last_rd;
    issue(1'b1, a, m, d);
    if (after) begin
      for (int i = 0; i < TA; i++) begin
        @(negedge clk);
        chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && !req_ready, "R6 turnaround idle",
            {28'h0, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe}, 32'he);
      end
    end
    for (int i = 0; i < WR; i++) begin
      @(negedge clk);
      if (i == 0 && !after) chk(!rsp_valid, "R5 valid pulse ended", {31'h0, rsp_valid}, 0);
      chk(!ram_ce_n && !ram_we_n && ram_oe_n && ram_be_n == ~m && ram_addr == a, "R2 write window",
          {ram_addr[13:0], ram_be_n, 13'h0, ram_ce_n, ram_we_n, ram_oe_n}, {a[13:0], ~m, 16'h1});
      chk(ram_dq_oe && ram_dq_o == d && !req_ready, "R3 drive during write",
          {15'h0, ram_dq_oe, ram_dq_o}, {16'h1, d});
    end
    @(negedge clk);
    chk(ram_we_n && ram_ce_n && ram_dq_oe && ram_dq_o == d && ram_addr == a && !req_ready, "R3 hold cycle",
        {13'h0, ram_we_n, ram_ce_n, ram_dq_oe, ram_dq_o}, {16'h7, d});
    @(negedge clk);
    chk(!ram_dq_oe && req_ready, "R9 write length", {30'h0, ram_dq_oe, req_ready}, 32'h1);
    if (m[0]) shadow[a[3:0]][7:0]  = d[7:0];
    if (m[1]) shadow[a[3:0]][15:8] = d[15:8];
    last_rd = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m);
    logic [15:0] exp;
    exp = {m[1] ? shadow[a[3:0]][15:8] : 8'h00, m[0] ? shadow[a[3:0]][7:0] : 8'h00};
    issue(1'b0, a, m, '0);
    for (int i = 0; i < RD; i++) begin
      @(negedge clk);
      chk(!ram_ce_n && !ram_oe_n && ram_we_n && !ram_dq_oe && ram_be_n == ~m && ram_addr == a,
          "R4 read window", {ram_addr[13:0], ram_be_n, 12'h0, ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe},
          {a[13:0], ~m, 16'h2});
      chk(!rsp_valid && !req_ready, "R9 read busy", {30'h0, rsp_valid, req_ready}, 0);
    end
    @(negedge clk);
    chk(ram_oe_n && ram_ce_n && rsp_valid && req_ready, "R5 valid at close",
        {29'h0, ram_oe_n, rsp_valid, req_ready}, 32'h7);
    chk(rsp_rdata == exp, "R5 read data", {16'h0, rsp_rdata}, {16'h0, exp});
    last_rd = 1'b1;
  endtask

  task automatic t_reset();
    chk(ram_ce_n && ram_we_n && ram_oe_n && ram_be_n == 2'b11 && !ram_dq_oe && !rsp_valid,
        "R1 strobes in reset", {26'h0, ram_ce_n, ram_we_n, ram_oe_n, ram_be_n, ram_dq_oe}, 32'h3e);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready && !rsp_valid,
        "R1 after release", {27'h0, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, req_ready}, 32'h1d);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready, "R7 idle no valid",
          {27'h0, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, req_ready}, 32'h1d);
    end
  endtask

  task automatic t_basic();
    do_write(18'd3, 2'b11, 16'h1234);
    do_write(18'd4, 2'b11, 16'h5678);
    do_read(18'd3, 2'b11);
    do_read(18'd4, 2'b11);
  endtask

  task automatic t_lane_read();
    do_read(18'd3, 2'b01); // R5 upper zeroed
    do_read(18'd3, 2'b10); // R5 lower zeroed
  endtask

  task automatic t_turn();
    do_read(18'd4, 2'b11);
    do_write(18'd5, 2'b11, 16'h9abc); // R6 after read
    do_write(18'd6, 2'b11, 16'hdef0); // R6 no gap
    do_read(18'd5, 2'b11);
  endtask

  task automatic t_partial();
    do_write(18'd3, 2'b01, 16'haabb); // R8 lower only
    do_read(18'd3, 2'b11);
    do_write(18'd3, 2'b10, 16'hccdd); // R8 upper only
    do_read(18'd3, 2'b11);
    chk(shadow[3] == 16'hccbb, "R8 lane merge model", {16'h0, shadow[3]}, 32'hccbb);
  endtask

  task automatic t_mask0();
    do_write(18'd4, 2'b00, 16'hffff); // R8 no lane
    do_read(18'd4, 2'b11);
    chk(mem[4] == 16'h5678, "R8 mask zero unchanged", {16'h0, mem[4]}, 32'h5678);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'(i * 16'h0101);
      shadow[i] = 16'(i * 16'h0101);
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_lane_read();
    t_turn();
    t_partial();
    t_mask0();
    t_idle();
    chk(contention == 0, "R3 no drive while output strobe low", contention, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule